// File: doc/BRIEF.md
# Morphable Counter Line Updater

This block keeps one 512-bit line that holds 128 write counters of a secure memory, together with a shared major counter and a 64-bit hash field. Each counter's effective value is the major counter plus that counter's own minor value. A caller increments a counter by its 7-bit index and reads any counter's effective value through a separate combinational read port. The block also presents the current encoded line.

The line has two encodings. While few counters are non-zero, a zero-compressed encoding is used. It holds a presence vector, plus a 256-bit region that carries only the non-zero minors, packed in ascending index order. Those minors are 16, 8 or 4 bits wide, depending on how many counters are non-zero. Once that no longer fits, the line uses a uniform encoding of 128 three-bit minors.

When a uniform minor would overflow, the block first tries to rebase. It moves the smallest minor into the major counter and subtracts it from every minor, so every effective value stays the same and no data needs re-encrypting. Only when rebasing cannot work does the block fall back to a reset, which raises every effective value and signals re-encryption.

Top module: `mctr_line`

## Requirements
- R1: After reset every effective value reads 0, the format code is 0, `inc_ready_o` is 1 and `reencrypt_o` is 0.
- R2: An increment is accepted on a clock edge where `inc_valid_i` and `inc_ready_o` are both 1. When the updated line still fits its encoding, the addressed counter reads one higher from the next cycle, and every other counter is unchanged.
- R3: The format code `fmt_o` is chosen from the count of non-zero minors (nz) and the largest minor (mx). The first rule that holds, in this order, decides it:
  - 0 (16-bit zero-compressed) if nz ≤ 16 and mx ≤ 65535;
  - 1 (8-bit zero-compressed) if nz ≤ 32 and mx ≤ 255;
  - 2 (4-bit zero-compressed) if nz ≤ 64 and mx ≤ 15;
  - otherwise 3 (uniform).
- R4: In a zero-compressed format, `line_o` has bit 511 = 0. Bit 256+j is 1 exactly when minor j is non-zero. The k-th non-zero minor in ascending index order sits at bits [k*W +: W] of the low 256 bits, with W equal to 16, 8 or 4 for codes 0, 1 and 2. All unused bits are 0.
- R5: In the uniform format, `line_o` has bit 511 = 1, and minor j sits at bits [3j+2:3j].
- R6: `line_o` bits [510:448] carry the major counter in every format. Bits [447:384] always equal `hash_i`.
- R7: The effective value is the arithmetic sum of the major counter and the minor. A change of format never alters any effective value.
- R8: If an increment would push a minor past the limit of every allowed format, and every minor is non-zero, the block rebases. The major counter grows by the smallest minor, that amount is taken from every minor, and then the increment is applied. Only the requested counter changes its effective value, and `reencrypt_o` stays 0.
- R9: If that rebase is impossible, the block resets the line instead. This happens when the smallest minor is 0, or when the rebased value would still exceed 7.
  - The major counter becomes the old largest effective value plus 1 and all minors clear.
  - The requested counter then reads the old largest effective value plus 2.
  - `reencrypt_o` is 1 for exactly one cycle.
- R10: A fast update keeps `inc_ready_o` at 1. A rebase or reset holds `inc_ready_o` at 0 for exactly one cycle, and any increment presented during that cycle is ignored.
- R11: No counter's effective value ever decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_valid_i | input | 1 | Increment request |
| inc_idx_i | input | 7 | Index of the counter to increment |
| inc_ready_o | output | 1 | High when a request can be accepted |
| rd_idx_i | input | 7 | Index of the counter to read |
| rd_value_o | output | 64 | Effective value of the counter at `rd_idx_i` |
| fmt_o | output | 2 | Current format code (R3) |
| reencrypt_o | output | 1 | One-cycle pulse after a reset of the line |
| hash_i | input | 64 | Hash field placed into the line unchanged |
| line_o | output | 512 | Encoded counter line |

## Verification
The bench walks the line through every format in turn:
- Increments to the first sixteen counters with differing counts check the 16-bit packing.
- Sweeps over 32 and then 64 counters check the 8-bit and 4-bit tiers.
- A 65th non-zero counter forces the uniform format.
- A large value followed by a seventeenth counter hits the value limit of a narrow tier and forces a reset.
- A fully populated uniform line that overflows rebases without re-encryption.
- A partly populated uniform line that overflows resets, which separates the rebase path from the reset path.

After each step, every effective value and the whole encoded line are compared against an arithmetic model.

// File: rtl/mctr_pkg.sv
package mctr_pkg;
    typedef enum logic [1:0] {
        FMT_Z16 = 2'd0,
        FMT_Z8  = 2'd1,
        FMT_Z4  = 2'd2,
        FMT_UNI = 2'd3
    } fmt_e;
endpackage

// File: rtl/mctr_stats.sv
module mctr_stats #(
    parameter int N_CTR = 128,
    parameter int MIN_W = 16,
    localparam int CNT_W = $clog2(N_CTR + 1)
) (
    input  logic [N_CTR-1:0][MIN_W-1:0] minor_i,
    output logic [CNT_W-1:0]            nz_o,
    output logic [MIN_W-1:0]            max_o,
    output logic [MIN_W-1:0]            min_o
);
    always_comb begin
        nz_o  = '0;
        max_o = '0;
        min_o = '1;
        for (int j = 0; j < N_CTR; j++) begin
            nz_o = nz_o + CNT_W'(minor_i[j] != '0);
            if (minor_i[j] > max_o) max_o = minor_i[j];
            if (minor_i[j] < min_o) min_o = minor_i[j];
        end
    end
endmodule

// File: rtl/mctr_fmt_sel.sv
module mctr_fmt_sel #(
    parameter int N_CTR   = 128,
    parameter int TIER0   = 16,
    parameter int ZW0     = 16,
    parameter int ZW1     = 8,
    parameter int ZW2     = 4,
    parameter int UW      = 3,
    parameter int VW      = 17,
    localparam int CNT_W  = $clog2(N_CTR + 1)
) (
    input  logic [CNT_W-1:0] nz_i,
    input  logic [VW-1:0]    max_i,
    output mctr_pkg::fmt_e   fmt_o,
    output logic             fits_o
);
    import mctr_pkg::*;

    localparam logic [VW-1:0] LIM0 = (VW'(1) << ZW0) - VW'(1);
    localparam logic [VW-1:0] LIM1 = (VW'(1) << ZW1) - VW'(1);
    localparam logic [VW-1:0] LIM2 = (VW'(1) << ZW2) - VW'(1);
    localparam logic [VW-1:0] LIMU = (VW'(1) << UW) - VW'(1);

    always_comb begin
        fits_o = 1'b1;
        if (nz_i <= CNT_W'(TIER0) && max_i <= LIM0) begin
            fmt_o = FMT_Z16;
        end else if (nz_i <= CNT_W'(2 * TIER0) && max_i <= LIM1) begin
            fmt_o = FMT_Z8;
        end else if (nz_i <= CNT_W'(4 * TIER0) && max_i <= LIM2) begin
            fmt_o = FMT_Z4;
        end else begin
            fmt_o  = FMT_UNI;
            fits_o = (max_i <= LIMU);
        end
    end
endmodule

// File: rtl/mctr_pack.sv
module mctr_pack #(
    parameter int N_CTR     = 128,
    parameter int MIN_W     = 16,
    parameter int MAJOR_W   = 63,
    parameter int HASH_W    = 64,
    parameter int ZREGION_W = 256,
    parameter int UW        = 3,
    parameter int ZW0       = 16,
    parameter int ZW1       = 8,
    parameter int ZW2       = 4,
    localparam int MREG_W   = N_CTR + ZREGION_W,
    localparam int LINE_W   = 1 + MAJOR_W + HASH_W + MREG_W
) (
    input  mctr_pkg::fmt_e              fmt_i,
    input  logic [N_CTR-1:0][MIN_W-1:0] minor_i,
    input  logic [MAJOR_W-1:0]          major_i,
    input  logic [HASH_W-1:0]           hash_i,
    output logic [LINE_W-1:0]           line_o
);
    import mctr_pkg::*;

    logic [ZREGION_W-1:0] packed_q;
    logic [N_CTR-1:0]     present;
    logic [MREG_W-1:0]    uni_region;

    // zero-compressed body: non-zero minors packed in ascending index order
    always_comb begin
        int pos;
        int zw;
        pos      = 0;
        packed_q = '0;
        present  = '0;
        case (fmt_i)
            FMT_Z16: zw = ZW0;
            FMT_Z8:  zw = ZW1;
            default: zw = ZW2;
        endcase
        for (int j = 0; j < N_CTR; j++) begin
            if (minor_i[j] != '0) begin
                present[j] = 1'b1;
                if (pos * zw < ZREGION_W)
                    packed_q = packed_q | (ZREGION_W'(minor_i[j]) << (pos * zw));
                pos = pos + 1;
            end
        end
    end

    generate
        for (genvar g = 0; g < N_CTR; g++) begin : g_uni
            assign uni_region[g*UW +: UW] = minor_i[g][UW-1:0];
        end
        if (MREG_W > N_CTR * UW) begin : g_pad
            assign uni_region[MREG_W-1:N_CTR*UW] = '0;
        end
    endgenerate

    always_comb begin
        line_o = '0;
        line_o[LINE_W-1] = (fmt_i == FMT_UNI);
        line_o[LINE_W-2 -: MAJOR_W] = major_i;
        line_o[MREG_W +: HASH_W] = hash_i;
        if (fmt_i == FMT_UNI) line_o[MREG_W-1:0] = uni_region;
        else                  line_o[MREG_W-1:0] = {present, packed_q};
    end
endmodule

// File: rtl/mctr_line.sv
module mctr_line #(
    parameter int N_CTR       = 128,
    parameter int MAJOR_W     = 63,
    parameter int HASH_W      = 64,
    parameter int MREG_W      = 384,
    parameter int TIER0       = 16,
    localparam int IDX_W      = $clog2(N_CTR),
    localparam int CNT_W      = $clog2(N_CTR + 1),
    localparam int ZREGION_W  = MREG_W - N_CTR,
    localparam int ZW0        = ZREGION_W / TIER0,
    localparam int ZW1        = ZREGION_W / (2 * TIER0),
    localparam int ZW2        = ZREGION_W / (4 * TIER0),
    localparam int UW         = MREG_W / N_CTR,
    localparam int MIN_W      = ZW0,
    localparam int VAL_W      = MAJOR_W + 1,
    localparam int LINE_W     = 1 + MAJOR_W + HASH_W + MREG_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               inc_valid_i,
    input  logic [IDX_W-1:0]   inc_idx_i,
    output logic               inc_ready_o,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [VAL_W-1:0]   rd_value_o,
    output logic [1:0]         fmt_o,
    output logic               reencrypt_o,
    input  logic [HASH_W-1:0]  hash_i,
    output logic [LINE_W-1:0]  line_o
);
    import mctr_pkg::*;

    localparam logic [MIN_W:0] UMAX = (MIN_W+1)'((1 << UW) - 1);

    typedef struct packed {
        logic                        busy;
        logic [IDX_W-1:0]            pidx;
        logic                        reenc;
        logic [MAJOR_W-1:0]          major;
        logic [N_CTR-1:0][MIN_W-1:0] minor;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0] nz_cur;
    logic [MIN_W-1:0] mx_cur, mn_cur;
    fmt_e             cur_fmt, cand_fmt;
    logic             cur_fits, cand_fits;

    logic [IDX_W-1:0] sel_idx;
    logic [MIN_W-1:0] cur_v;
    logic [MIN_W:0]   cand_v, cand_mx, rebased_v;
    logic [CNT_W-1:0] cand_nz;
    logic             can_rebase;

    mctr_stats #(.N_CTR(N_CTR), .MIN_W(MIN_W)) stats_i (
        .minor_i (s_q.minor),
        .nz_o    (nz_cur),
        .max_o   (mx_cur),
        .min_o   (mn_cur)
    );

    mctr_fmt_sel #(
        .N_CTR(N_CTR), .TIER0(TIER0), .ZW0(ZW0), .ZW1(ZW1), .ZW2(ZW2),
        .UW(UW), .VW(MIN_W + 1)
    ) cur_sel_i (
        .nz_i   (nz_cur),
        .max_i  ({1'b0, mx_cur}),
        .fmt_o  (cur_fmt),
        .fits_o (cur_fits)
    );

    mctr_fmt_sel #(
        .N_CTR(N_CTR), .TIER0(TIER0), .ZW0(ZW0), .ZW1(ZW1), .ZW2(ZW2),
        .UW(UW), .VW(MIN_W + 1)
    ) cand_sel_i (
        .nz_i   (cand_nz),
        .max_i  (cand_mx),
        .fmt_o  (cand_fmt),
        .fits_o (cand_fits)
    );

    // candidate line after applying the pending or offered increment
    always_comb begin
        sel_idx    = s_q.busy ? s_q.pidx : inc_idx_i;
        cur_v      = s_q.minor[sel_idx];
        cand_v     = {1'b0, cur_v} + (MIN_W+1)'(1);
        cand_nz    = nz_cur + CNT_W'(cur_v == '0);
        cand_mx    = (cand_v > {1'b0, mx_cur}) ? cand_v : {1'b0, mx_cur};
        rebased_v  = cand_v - {1'b0, mn_cur};
        can_rebase = (mn_cur != '0) && ((cand_mx - {1'b0, mn_cur}) <= UMAX);
    end

    always_comb begin
        s_d       = s_q;
        s_d.reenc = 1'b0;
        if (!s_q.busy) begin
            if (inc_valid_i) begin
                if (cand_fits) begin
                    s_d.minor[inc_idx_i] = cand_v[MIN_W-1:0];
                end else begin
                    s_d.busy = 1'b1;
                    s_d.pidx = inc_idx_i;
                end
            end
        end else begin
            s_d.busy = 1'b0;
            if (can_rebase) begin
                s_d.major = s_q.major + MAJOR_W'(mn_cur);
                for (int j = 0; j < N_CTR; j++)
                    s_d.minor[j] = s_q.minor[j] - mn_cur;
                s_d.minor[s_q.pidx] = rebased_v[MIN_W-1:0];
            end else begin
                s_d.major = s_q.major + MAJOR_W'(mx_cur) + MAJOR_W'(1);
                s_d.minor = '0;
                s_d.minor[s_q.pidx] = MIN_W'(1);
                s_d.reenc = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign inc_ready_o = !s_q.busy;
    assign reencrypt_o = s_q.reenc;
    assign rd_value_o  = {1'b0, s_q.major} + VAL_W'(s_q.minor[rd_idx_i]);
    assign fmt_o       = cur_fits ? cur_fmt : FMT_UNI;

    mctr_pack #(
        .N_CTR(N_CTR), .MIN_W(MIN_W), .MAJOR_W(MAJOR_W), .HASH_W(HASH_W),
        .ZREGION_W(ZREGION_W), .UW(UW), .ZW0(ZW0), .ZW1(ZW1), .ZW2(ZW2)
    ) pack_i (
        .fmt_i   (fmt_e'(fmt_o)),
        .minor_i (s_q.minor),
        .major_i (s_q.major),
        .hash_i  (hash_i),
        .line_o  (line_o)
    );
endmodule

// File: rtl/mctr_line_chk.sv
module mctr_line_chk #(
    parameter int IDX_W = 7,
    parameter int VAL_W = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             inc_valid_i,
    input logic [IDX_W-1:0] inc_idx_i,
    input logic             inc_ready_o,
    input logic [IDX_W-1:0] rd_idx_i,
    input logic [VAL_W-1:0] rd_value_o,
    input logic             reencrypt_o
);
    // R10
    busy_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inc_ready_o |=> inc_ready_o);

    // R9
    reenc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reencrypt_o |=> !reencrypt_o);

    // R9
    reenc_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reencrypt_o |-> $past(!inc_ready_o));

    // R11
    monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(rd_idx_i) |-> rd_value_o >= $past(rd_value_o));

    // R2
    inc_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_valid_i && inc_ready_o && rd_idx_i == inc_idx_i) |=>
        (!inc_ready_o || !$stable(rd_idx_i) || rd_value_o == $past(rd_value_o) + VAL_W'(1)));
endmodule

bind mctr_line mctr_line_chk #(.IDX_W(IDX_W), .VAL_W(VAL_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_valid_i (inc_valid_i),
    .inc_idx_i   (inc_idx_i),
    .inc_ready_o (inc_ready_o),
    .rd_idx_i    (rd_idx_i),
    .rd_value_o  (rd_value_o),
    .reencrypt_o (reencrypt_o)
);

// File: tb/mctr_line_tb.sv
module mctr_line_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         inc_valid = 1'b0;
    logic [6:0]   inc_idx = '0;
    logic         inc_ready;
    logic [6:0]   rd_idx = '0;
    logic [63:0]  rd_value;
    logic [1:0]   fmt;
    logic         reenc;
    logic [63:0]  hash_v = 64'hA5C3_0F1E_9B27_6D48;
    logic [511:0] line;

    always #4 clk = ~clk;

    mctr_line dut_i (
        .clk_i(clk), .rst_ni(rst_n), .inc_valid_i(inc_valid), .inc_idx_i(inc_idx),
        .inc_ready_o(inc_ready), .rd_idx_i(rd_idx), .rd_value_o(rd_value),
        .fmt_o(fmt), .reencrypt_o(reenc), .hash_i(hash_v), .line_o(line)
    );

    int errs = 0;
    int checks = 0;
    longint unsigned mj = 0;
    int mn [128];
    bit done = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nz_cnt();
        int n = 0;
        for (int j = 0; j < 128; j++) if (mn[j] != 0) n++;
        return n;
    endfunction

    function automatic int mx_val();
        int m = 0;
        for (int j = 0; j < 128; j++) if (mn[j] > m) m = mn[j];
        return m;
    endfunction

    function automatic int mn_val();
        int m = 65535;
        for (int j = 0; j < 128; j++) if (mn[j] < m) m = mn[j];
        return m;
    endfunction

    // 0..3 per R3, 4 when nothing fits
    function automatic int classify(input int nz, input int mx);
        if (nz <= 16 && mx <= 65535) return 0;
        if (nz <= 32 && mx <= 255)   return 1;
        if (nz <= 64 && mx <= 15)    return 2;
        if (mx <= 7)                 return 3;
        return 4;
    endfunction

    task automatic model_inc(input int idx, output bit slow, output bit rs);
        int v, nz, mx, s;
        v  = mn[idx] + 1;
        nz = nz_cnt() + ((mn[idx] == 0) ? 1 : 0);
        mx = (mx_val() > v) ? mx_val() : v;
        slow = 0;
        rs   = 0;
        if (classify(nz, mx) != 4) begin
            mn[idx] = v;
        end else begin
            slow = 1;
            s = mn_val();
            if (s != 0 && mx - s <= 7) begin
                mj = mj + longint'(s);
                for (int j = 0; j < 128; j++) mn[j] = mn[j] - s;
                mn[idx] = v - s;
            end else begin
                rs = 1;
                mj = mj + longint'(mx_val()) + 1;
                for (int j = 0; j < 128; j++) mn[j] = 0;
                mn[idx] = 1;
            end
        end
    endtask

    function automatic logic [511:0] exp_line();
        logic [511:0] l;
        int f, w, pos;
        f = classify(nz_cnt(), mx_val());
        l = '0;
        l[511] = (f == 3);
        l[510:448] = mj[62:0];
        l[447:384] = hash_v;
        if (f == 3) begin
            for (int j = 0; j < 128; j++)
                for (int b = 0; b < 3; b++) l[3*j+b] = ((mn[j] >> b) & 1) != 0;
        end else begin
            w = 16 >> f;
            pos = 0;
            for (int j = 0; j < 128; j++) begin
                if (mn[j] != 0) begin
                    l[256+j] = 1'b1;
                    for (int b = 0; b < w; b++) l[pos*w+b] = ((mn[j] >> b) & 1) != 0;
                    pos++;
                end
            end
        end
        return l;
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < 128; i++) begin
            rd_idx = 7'(i);
            #1;
            chk(req, rd_value, mj + longint'(mn[i]));
        end
    endtask

    task automatic check_state(input string req_line);
        logic [511:0] e;
        e = exp_line();
        chk("R3", 64'(fmt), 64'(classify(nz_cnt(), mx_val())));
        checks++;
        if (line !== e) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req_line, line, e);
        end
    endtask

    task automatic do_inc(input int idx);
        bit slow, rs;
        @(negedge clk);
        inc_valid = 1'b1;
        inc_idx = 7'(idx);
        model_inc(idx, slow, rs);
        @(negedge clk);
        inc_valid = 1'b0;
        if (slow) begin
            chk("R10", 64'(inc_ready), 64'd0);
            @(negedge clk);
            chk("R9", 64'(reenc), 64'(rs));
        end else begin
            chk("R10", 64'(inc_ready), 64'd1);
        end
    endtask

    // slow update while a second request is held during the busy cycle
    task automatic do_inc_hold(input int idx, input int other);
        bit slow, rs;
        @(negedge clk);
        inc_valid = 1'b1;
        inc_idx = 7'(idx);
        model_inc(idx, slow, rs);
        @(negedge clk);
        chk("R10", 64'(inc_ready), 64'(!slow));
        inc_idx = 7'(other);
        @(negedge clk);
        inc_valid = 1'b0;
        chk("R8", 64'(reenc), 64'(rs));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int j = 0; j < 128; j++) mn[j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", 64'(inc_ready), 64'd1);
        chk("R1", 64'(reenc), 64'd0);
        chk("R1", 64'(fmt), 64'd0);
        check_all("R1");
        check_state("R6");

        // 16-bit tier, differing counts, then one large value
        for (int i = 0; i < 16; i++)
            for (int k = 0; k <= i; k++) do_inc(i);
        check_all("R2");
        check_state("R4");
        for (int k = 0; k < 284; k++) do_inc(5);
        check_all("R2");
        check_state("R4");

        // seventeenth counter with a value above 255: reset fallback
        do_inc(16);
        check_all("R9 R11");
        check_state("R6");

        // 8-bit, then 4-bit tier
        for (int i = 0; i < 32; i++) do_inc(i);
        check_state("R4");
        check_all("R7");
        for (int i = 32; i < 64; i++) do_inc(i);
        check_state("R4");

        // 65th non-zero counter: uniform
        do_inc(64);
        check_state("R5");
        check_all("R7");

        // fill all counters, then overflow counter 0: rebase
        for (int i = 65; i < 128; i++) do_inc(i);
        for (int k = 0; k < 6; k++) do_inc(0);
        check_state("R5");
        do_inc_hold(0, 99);
        check_all("R8 R10");
        check_state("R6");

        // partly populated uniform line overflows: reset
        for (int i = 1; i <= 70; i++) if (i != 16) do_inc(i);
        check_state("R5");
        do_inc(0);
        check_all("R9");
        check_state("R4");

        // 4-bit tier value limit reached
        for (int i = 1; i <= 40; i++) do_inc(i);
        for (int k = 0; k < 14; k++) do_inc(1);
        check_state("R4");
        do_inc(1);
        check_all("R3 R9");
        check_state("R6");

        finish_run();
    end
endmodule